// File: doc/BRIEF.md
# Byte-Register UART Frame and Status Core

This block is the control and status heart of a small serial port that a processor drives through four byte-wide registers. It formats outgoing bytes into asynchronous frames with one start bit, eight or nine frame bits and a single stop bit. It adds or checks parity. It can hold the line low as a break. It reports progress through a status byte that firmware polls or that raises an interrupt. Each direction has its own serial shifter. Both run from an external tick that arrives `OVS` times per bit. The transmit side has a one-deep holding register in front of its shifter, and the receive side has a one-deep data register behind its shifter.

Software picks the frame layout in a format register, turns the directions and interrupt sources on in an enable register, writes bytes to send into the data register, and reads received bytes from that same register. Error flags are sticky. They clear only when the status register is read and the data register is read as the very next register access.

Register select: 0 = format, 1 = enable, 2 = status, 3 = data. Format byte: bit4 `W9` (9-bit frame), bit1 `PEN` (parity on), bit0 `POD` (odd parity). Enable byte: bit7 TX-empty irq enable, bit6 TX-done irq enable, bit5 RX-full irq enable, bit3 `TXEN`, bit2 `RXEN`, bit0 `BRK`. Status byte: bit7 `TDRE`, bit6 `TC`, bit5 `RDRF`, bit4 `IDLE`, bit3 `OVR`, bit2 `NF`, bit1 `FE`, bit0 `PF`.

Top module: `uart_frame_ctl`

## Requirements
- R1: After reset the format and enable registers read 0x00, status reads 0xC0 (TDRE and TC set, all else clear), txd is high and irq is low.
- R2: A transmitted frame is a low start bit, then the frame bits LSB first, then a high stop bit, each bit `OVS` ticks long. With W9=0 there are 8 frame bits: data[7:0] without parity, or data[6:0] plus parity with PEN=1. With W9=1 there are 9 frame bits: data[7:0], then parity if PEN=1, or a 1 if PEN=0.
- R3: The parity bit makes the number of ones over the data bits and the parity bit even when POD=0 and odd when POD=1.
- R4: A write to the data register clears TDRE. The byte moves to the shifter as soon as the shifter is free and TXEN=1, and TDRE then sets again. TC reads 1 only when TDRE=1 and no frame is on the line.
- R5: Clearing TXEN lets a frame already on the line finish. No new frame starts while TXEN=0, so the line stays high and a pending byte keeps TDRE at 0.
- R6: While BRK=1 and TXEN=1 the line is held low continuously, in all-zero frames of full frame length. After BRK is cleared, the current break frame ends and the line returns high.
- R7: A received frame loads the data register and sets RDRF. With W9=0 and PEN=1, bit7 of the received byte reads 0. Reading the data register clears RDRF.
- R8: A parity mismatch on a received frame sets PF, and a low stop bit sets FE. Both apply to the frame that is stored.
- R9: Each received bit is sampled three times around its centre. The bit takes the majority value, and NF is set if the three samples disagree in any bit of the frame.
- R10: A frame that completes while RDRF=1 sets OVR and is discarded, so the data register keeps the older byte.
- R11: OVR, NF, FE, PF and IDLE clear when a status read is followed by a data read as the next register access. A data read not preceded by a status read leaves them set.
- R12: After a frame is received, IDLE sets once the line has stayed high for one full frame time. It does not set again until another frame has been received.
- R13: irq is high exactly when (TDRE and its enable), (TC and its enable) or (RDRF and its enable) holds.
- R14: With RXEN=0 the receiver ignores rxd, so no frame sets RDRF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Oversampling tick, `OVS` per bit |
| reg_sel | input | 2 | Register select |
| reg_rd | input | 1 | Read strobe; side effects at the clock edge |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_sel`, combinational |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| irq | output | 1 | Interrupt request |

## Verification
Most internal faults show up on txd within one frame. A wrong shift count, a bad parity term or a misordered bit changes the sampled waveform within ten or eleven bit times, and a broken break or enable shows as a stray high or low sample. Receive faults stay hidden until the next status and data reads. The flags and byte read back at that point reveal a wrong vote, a dropped overrun or a flag clear that fires at the wrong time. IDLE faults show only after a full frame time of quiet line.

// File: rtl/uart_frame_ctl.sv
module uart_frame_ctl #(
  parameter int OVS  = 16,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic [1:0] reg_sel,
  input  logic       reg_rd,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       rxd,
  output logic       txd,
  output logic       irq
);
  localparam int CW  = $clog2(OVS);
  localparam int IDW = $clog2(11 * OVS + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(OVS - 1);
  localparam logic [CW-1:0] SMP_A   = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] SMP_B   = CW'(OVS / 2);
  localparam logic [CW-1:0] SMP_C   = CW'(OVS / 2 + 1);
  localparam logic [1:0] SEL_FMT = 2'd0, SEL_CTL = 2'd1, SEL_STAT = 2'd2, SEL_DATA = 2'd3;

  logic fmt_m, fmt_pe, fmt_pt;
  logic en_tie, en_tcie, en_rie, en_tx, en_rx, en_brk;

  wire wr_fmt  = reg_wr && (reg_sel == SEL_FMT);
  wire wr_ctl  = reg_wr && (reg_sel == SEL_CTL);
  wire wr_data = reg_wr && (reg_sel == SEL_DATA);
  wire rd_stat = reg_rd && (reg_sel == SEL_STAT);
  wire rd_data = reg_rd && (reg_sel == SEL_DATA);

  wire [3:0] frame_len = fmt_m ? 4'd11 : 4'd10;
  wire [3:0] stop_idx  = fmt_m ? 4'd10 : 4'd9;
  wire [IDW-1:0] idle_limit = fmt_m ? IDW'(11 * OVS - 1) : IDW'(10 * OVS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {fmt_m, fmt_pe, fmt_pt} <= '0;
      {en_tie, en_tcie, en_rie, en_tx, en_rx, en_brk} <= '0;
    end else begin
      if (wr_fmt) {fmt_m, fmt_pe, fmt_pt} <= {reg_wdata[4], reg_wdata[1], reg_wdata[0]};
      if (wr_ctl) {en_tie, en_tcie, en_rie, en_tx, en_rx, en_brk} <=
          {reg_wdata[7], reg_wdata[6], reg_wdata[5], reg_wdata[3], reg_wdata[2], reg_wdata[0]};
    end
  end

  function automatic logic [10:0] tx_frame(input logic [7:0] d, input logic m, input logic pe,
                                           input logic pt);
    logic [10:0] f;
    f = 11'h7FE;
    if (m) begin
      f[8:1] = d;
      f[9]   = pe ? (^d ^ pt) : 1'b1;
    end else if (pe) begin
      f[7:1] = d[6:0];
      f[8]   = ^d[6:0] ^ pt;
    end else begin
      f[8:1] = d;
    end
    return f;
  endfunction

  // transmit path
  logic [7:0]    tdr;
  logic          tdre, tx_busy, tx_brk;
  logic [10:0]   tx_sh;
  logic [3:0]    tx_left;
  logic [CW-1:0] tx_cnt;

  wire tx_go_brk = en_tx && en_brk && !tx_busy;
  wire tx_go_dat = en_tx && !en_brk && !tdre && !tx_busy;
  wire tc        = tdre && !tx_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdr <= '0; tdre <= 1'b1; tx_busy <= 1'b0; tx_brk <= 1'b0;
      tx_sh <= '1; tx_left <= '0; tx_cnt <= '0;
    end else begin
      if (tx_go_brk) begin
        tx_busy <= 1'b1; tx_brk <= 1'b1; tx_sh <= '0; tx_left <= frame_len; tx_cnt <= '0;
      end else if (tx_go_dat) begin
        tx_busy <= 1'b1; tx_brk <= 1'b0; tx_sh <= tx_frame(tdr, fmt_m, fmt_pe, fmt_pt);
        tx_left <= frame_len; tx_cnt <= '0; tdre <= 1'b1;
      end else if (tx_busy && baud_tick) begin
        if (tx_cnt == CNT_TOP) begin
          tx_cnt <= '0;
          if (tx_left == 4'd1) begin
            tx_busy <= 1'b0; tx_brk <= 1'b0;
          end else begin
            tx_sh <= {1'b1, tx_sh[10:1]}; tx_left <= tx_left - 4'd1;
          end
        end else begin
          tx_cnt <= tx_cnt + 1'b1;
        end
      end
      if (wr_data) begin
        tdr <= reg_wdata; tdre <= 1'b0;
      end
    end
  end

  assign txd = tx_busy ? tx_sh[0] : !(en_tx && en_brk);

  // receive path
  logic [SYNC-1:0] rx_sync;
  logic            rx_busy, rx_nf_acc;
  logic [CW-1:0]   rx_cnt;
  logic [3:0]      rx_bit;
  logic [1:0]      rx_smp;
  logic [8:0]      rx_sh;

  wire rx_s     = rx_sync[SYNC-1];
  wire rx_maj   = (rx_smp[0] & rx_smp[1]) | (rx_smp[0] & rx_s) | (rx_smp[1] & rx_s);
  wire rx_split = !((rx_smp[0] == rx_smp[1]) && (rx_smp[1] == rx_s));
  wire rx_eval  = en_rx && rx_busy && baud_tick && (rx_cnt == SMP_C);
  wire rx_done  = rx_eval && (rx_bit == stop_idx);

  wire [7:0] rx_byte = (!fmt_m && fmt_pe) ? {1'b0, rx_sh[6:0]} : rx_sh[7:0];
  wire rx_par_bad = fmt_pe && (fmt_m ? ((^rx_sh[8:0]) != fmt_pt) : ((^rx_sh[7:0]) != fmt_pt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sync <= '1; rx_busy <= 1'b0; rx_nf_acc <= 1'b0; rx_cnt <= '0;
      rx_bit <= '0; rx_smp <= '1; rx_sh <= '0;
    end else begin
      rx_sync <= {rx_sync[SYNC-2:0], rxd};
      if (!en_rx) begin
        rx_busy <= 1'b0;
      end else if (!rx_busy) begin
        if (baud_tick && !rx_s) begin
          rx_busy <= 1'b1; rx_cnt <= CW'(1); rx_bit <= '0; rx_nf_acc <= 1'b0;
        end
      end else if (baud_tick) begin
        rx_cnt <= (rx_cnt == CNT_TOP) ? '0 : rx_cnt + 1'b1;
        if (rx_cnt == SMP_A) rx_smp[0] <= rx_s;
        if (rx_cnt == SMP_B) rx_smp[1] <= rx_s;
        if (rx_cnt == SMP_C) begin
          rx_nf_acc <= rx_nf_acc | rx_split;
          rx_bit    <= rx_bit + 4'd1;
          if ((rx_bit == 4'd0 && rx_maj) || rx_bit == stop_idx) rx_busy <= 1'b0;
          else if (rx_bit != 4'd0) rx_sh[rx_bit - 4'd1] <= rx_maj;
        end
      end
    end
  end

  // status flags
  logic [7:0]     rdr;
  logic           rdrf, ovr, nf, fe, pf, idle_flag, rd_arm, idle_arm;
  logic [IDW-1:0] idle_cnt;

  wire idle_quiet = en_rx && !rx_busy && rx_s;
  wire idle_fire  = idle_quiet && baud_tick && idle_arm && (idle_cnt == idle_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdr <= '0; {rdrf, ovr, nf, fe, pf, idle_flag, rd_arm, idle_arm} <= '0; idle_cnt <= '0;
    end else begin
      if (reg_rd || reg_wr) rd_arm <= rd_stat;
      if (rd_data) begin
        rdrf <= 1'b0;
        if (rd_arm) {ovr, nf, fe, pf, idle_flag} <= '0;
      end
      if (!idle_quiet) idle_cnt <= '0;
      else if (baud_tick && idle_arm) idle_cnt <= idle_fire ? '0 : idle_cnt + 1'b1;
      if (idle_fire) begin
        idle_flag <= 1'b1; idle_arm <= 1'b0;
      end
      if (rx_done) begin
        idle_arm <= 1'b1;
        if (rdrf) begin
          ovr <= 1'b1;
        end else begin
          rdr <= rx_byte; rdrf <= 1'b1;
          if (rx_nf_acc || rx_split) nf <= 1'b1;
          if (!rx_maj) fe <= 1'b1;
          if (rx_par_bad) pf <= 1'b1;
        end
      end
    end
  end

  wire [7:0] status = {tdre, tc, rdrf, idle_flag, ovr, nf, fe, pf};

  always_comb begin
    case (reg_sel)
      SEL_FMT:  reg_rdata = {3'b000, fmt_m, 2'b00, fmt_pe, fmt_pt};
      SEL_CTL:  reg_rdata = {en_tie, en_tcie, en_rie, 1'b0, en_tx, en_rx, 1'b0, en_brk};
      SEL_STAT: reg_rdata = status;
      default:  reg_rdata = rdr;
    endcase
  end

  assign irq = (tdre && en_tie) || (tc && en_tcie) || (rdrf && en_rie);
endmodule

// File: rtl/uart_frame_ctl_chk.sv
module uart_frame_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txd,
  input logic       tx_busy,
  input logic       tx_brk,
  input logic       en_tx,
  input logic       tdre,
  input logic       wr_data,
  input logic       rdrf,
  input logic       rx_done,
  input logic       rd_data,
  input logic       rd_arm,
  input logic       idle_fire,
  input logic [4:0] err_flags
);
  p_break_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && tx_brk) |-> !txd);

  p_no_start_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_tx && !tx_busy) |=> !tx_busy);

  p_tdre_by_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tdre) |-> $past(wr_data));

  p_rdrf_by_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdrf) |-> $past(rx_done));

  p_flag_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && rd_arm && !rx_done && !idle_fire) |=> (err_flags == 5'd0));
endmodule

bind uart_frame_ctl uart_frame_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .tx_busy(tx_busy), .tx_brk(tx_brk),
  .en_tx(en_tx), .tdre(tdre), .wr_data(wr_data), .rdrf(rdrf), .rx_done(rx_done),
  .rd_data(rd_data), .rd_arm(rd_arm), .idle_fire(idle_fire),
  .err_flags({ovr, nf, fe, pf, idle_flag})
);

// File: tb/tb_uart_frame_ctl.sv
`timescale 1ns/1ps
module tb_uart_frame_ctl;
  logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b1;
  logic [1:0] reg_sel = 2'd0;
  logic reg_rd = 1'b0, reg_wr = 1'b0, rxd = 1'b1;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic txd, irq;
  int n_cmp = 0, n_bad = 0;

  uart_frame_ctl dut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  function automatic logic [10:0] exp_frame(input logic [7:0] d, input logic m, input logic pe,
                                            input logic pt);
    logic [10:0] f;
    f = '1; f[0] = 1'b0;
    if (m) begin
      for (int i = 0; i < 8; i++) f[1+i] = d[i];
      f[9] = pe ? ((^d) ^ pt) : 1'b1;
    end else if (pe) begin
      for (int i = 0; i < 7; i++) f[1+i] = d[i];
      f[8] = (^d[6:0]) ^ pt;
    end else begin
      for (int i = 0; i < 8; i++) f[1+i] = d[i];
    end
    return f;
  endfunction

  function automatic logic [7:0] exp_rx(input logic [7:0] d, input logic m, input logic pe);
    return (!m && pe) ? {1'b0, d[6:0]} : d;
  endfunction

  task automatic tx_capture(input int len, output logic [10:0] f);
    int guard = 0;
    f = '1;
    do begin @(negedge clk); guard++; end while (txd && guard < 3000);
    repeat (8) @(negedge clk);
    f[0] = txd;
    for (int k = 1; k < len; k++) begin
      repeat (16) @(negedge clk);
      f[k] = txd;
    end
  endtask

  task automatic rx_send(input logic [10:0] f, input int len, input int gl);
    for (int c = 0; c < len * 16; c++) begin
      @(negedge clk); rxd = f[c / 16] ^ (c == gl);
    end
    @(negedge clk); rxd = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++; n_cmp++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] s, v, d;
    logic [10:0] got, f;
    logic m, pe, pt, perr;
    int len, cnt;
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 txd", txd, 1'b1);
    chk("R1 irq", irq, 1'b0);
    rd(2'd2, s); chk("R1 status", s, 8'hC0);
    rd(2'd0, s); chk("R1 format", s, 8'h00);
    rd(2'd1, s); chk("R1 enable", s, 8'h00);

    wr(2'd1, 8'h80); @(negedge clk); chk("R13 tie", irq, 1'b1);
    wr(2'd1, 8'h00); @(negedge clk); chk("R13 off", irq, 1'b0);

    // directed 8N1 transmit
    wr(2'd0, 8'h00); wr(2'd1, 8'h0C);
    fork
      tx_capture(10, got);
      begin wr(2'd3, 8'hA5); rd(2'd2, s); chk("R4 busy status", s & 8'hC0, 8'h80); end
    join
    chk("R2 8N1 frame", got, exp_frame(8'hA5, 0, 0, 0));
    repeat (12) @(negedge clk);
    rd(2'd2, s); chk("R4 tc after", s & 8'hC0, 8'hC0);

    // back-to-back bytes, 8 data + even parity
    wr(2'd0, 8'h12);
    fork
      begin
        tx_capture(11, got); chk("R2 first of pair", got, exp_frame(8'h3C, 1, 1, 0));
        tx_capture(11, got); chk("R3 second of pair", got, exp_frame(8'hC1, 1, 1, 0));
      end
      begin wr(2'd3, 8'h3C); wr(2'd3, 8'hC1); rd(2'd2, s); chk("R4 held", s & 8'hC0, 8'h00); end
    join
    repeat (12) @(negedge clk);

    // random formats, transmit and receive
    for (int it = 0; it < 16; it++) begin
      int mode;
      mode = $urandom_range(0, 5);
      d = 8'($urandom);
      m  = (mode >= 3);
      pe = (mode != 0) && (mode != 5);
      pt = (mode == 2) || (mode == 4);
      len = m ? 11 : 10;
      wr(2'd0, {3'b000, m, 2'b00, pe, pt});
      fork
        tx_capture(len, got);
        wr(2'd3, d);
      join
      chk("R2/R3 random frame", got, exp_frame(d, m, pe, pt));
      repeat (12) @(negedge clk);
      f = exp_frame(d, m, pe, pt);
      perr = pe && (it % 3 == 0);
      if (perr) begin
        if (m) f[9] = ~f[9]; else f[8] = ~f[8];
      end
      rx_send(f, len, -1);
      rd(2'd2, s); chk("R8 random status", s & 8'hEF, 8'hE0 | {7'd0, perr});
      rd(2'd3, v); chk("R7 random byte", v, exp_rx(d, m, pe));
    end

    // noise on data bit 3, 8N1
    wr(2'd0, 8'h00);
    rx_send(exp_frame(8'h3C, 0, 0, 0), 10, 72);
    rd(2'd2, s); chk("R9 noise flag", s & 8'hEF, 8'hE4);
    rd(2'd3, v); chk("R9 majority byte", v, 8'h3C);

    // framing error
    f = exp_frame(8'h55, 0, 0, 0); f[9] = 1'b0;
    rx_send(f, 10, -1);
    rd(2'd2, s); chk("R8 framing", s & 8'hEF, 8'hE2);
    rd(2'd3, v); chk("R8 framing byte", v, 8'h55);

    // data read without status read keeps errors
    rx_send(f, 10, -1);
    wr(2'd1, 8'h0C);
    rd(2'd3, v); chk("R11 byte", v, 8'h55);
    rd(2'd2, s); chk("R11 kept", s & 8'hEF, 8'hC2);
    rd(2'd3, v);
    rd(2'd2, s); chk("R11 cleared", s & 8'hEF, 8'hC0);

    // overrun
    rx_send(exp_frame(8'h11, 0, 0, 0), 10, -1);
    rx_send(exp_frame(8'h22, 0, 0, 0), 10, -1);
    rd(2'd2, s); chk("R10 overrun status", s & 8'hEF, 8'hE8);
    rd(2'd3, v); chk("R10 older byte", v, 8'h11);
    rd(2'd2, s); chk("R11 overrun cleared", s & 8'hEF, 8'hC0);

    // idle flag
    rx_send(exp_frame(8'h7E, 0, 0, 0), 10, -1);
    rd(2'd2, s); rd(2'd3, v);
    repeat (11 * 16 + 40) @(negedge clk);
    rd(2'd2, s); chk("R12 idle set", s[4], 1'b1);
    rd(2'd3, v);
    rd(2'd2, s); chk("R12 idle cleared", s[4], 1'b0);
    repeat (11 * 16 + 40) @(negedge clk);
    rd(2'd2, s); chk("R12 no rearm", s[4], 1'b0);

    // receiver off
    wr(2'd1, 8'h08);
    rx_send(exp_frame(8'h99, 0, 0, 0), 10, -1);
    rd(2'd2, s); chk("R14 ignored", s, 8'hC0);

    // interrupt sources
    wr(2'd1, 8'h24);
    rx_send(exp_frame(8'h42, 0, 0, 0), 10, -1);
    chk("R13 rie", irq, 1'b1);
    rd(2'd2, s); rd(2'd3, v);
    @(negedge clk); chk("R13 rie clear", irq, 1'b0);
    wr(2'd1, 8'h48); @(negedge clk); chk("R13 tcie", irq, 1'b1);

    // transmitter disable mid-frame
    wr(2'd1, 8'h08);
    fork
      tx_capture(10, got);
      wr(2'd3, 8'h96);
      begin repeat (60) @(negedge clk); wr(2'd1, 8'h00); end
    join
    chk("R5 frame finished", got, exp_frame(8'h96, 0, 0, 0));
    repeat (12) @(negedge clk);
    wr(2'd3, 8'h5A);
    cnt = 0;
    repeat (300) begin @(negedge clk); if (!txd) cnt++; end
    chk("R5 line quiet", cnt, 0);
    rd(2'd2, s); chk("R5 pending", s & 8'hC0, 8'h00);
    fork
      tx_capture(10, got);
      wr(2'd1, 8'h08);
    join
    chk("R5 resumes", got, exp_frame(8'h5A, 0, 0, 0));
    repeat (12) @(negedge clk);

    // break
    wr(2'd1, 8'h09);
    repeat (3) @(negedge clk);
    cnt = 0;
    repeat (400) begin @(negedge clk); if (txd) cnt++; end
    chk("R6 held low", cnt, 0);
    wr(2'd1, 8'h08);
    repeat (11 * 16 + 10) @(negedge clk);
    cnt = 0;
    repeat (60) begin @(negedge clk); if (!txd) cnt++; end
    chk("R6 released", cnt, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule